// File: doc/BRIEF.md
# Stereo Serial Audio Port

This block moves 16-bit stereo samples between a parallel interface and a four-wire serial audio link. The four wires are the bit clock, the frame clock, serial data in and serial data out. The port runs in one of two roles.

As clock master it divides a source clock down to the bit clock and generates the frame clock. The source is either the system clock or a dedicated master clock input. As clock slave it oversamples the external bit clock and frame clock on the system clock. It stays silent until it sees the frame-clock edge that opens a left channel.

Once framing has begun, the port shifts data without pause. When the transmit FIFO has nothing to give, the port sends a programmable filler word or zeros in its place. Received words collect in a four-entry receive FIFO, which can be read on the parallel side.

Top module: `aud_port`

## Requirements
- R1: In master mode with the system clock selected, each bit-clock period lasts exactly 2×(div_i+1) system clocks. The bit clock keeps toggling whether or not transmit data is present.
- R2: In master mode, the first bit-clock edge after en_i rises appears within 2×(div_i+1) system clocks. While that edge appears, lrclk_o is low, which marks the left slot.
- R3: A frame is two 16-bit slots: left while the frame clock is low, right while it is high. Data goes out most-significant bit first. The first bit of each slot is driven on the drive edge that starts the slot. The port sends transmit FIFO words in FIFO order, alternating left and right, and pushes received words in arrival order.
- R4: In slave mode, sdo_o stays 0 and nothing is captured until the first high-to-low transition of lrclk_i after enable. From that transition on, shifting in both directions is continuous.
- R5: While rx_dis_i is high, no received word enters the receive FIFO. Transmit shifting continues unaffected.
- R6: When a slot starts with the transmit FIFO empty, the port sends urun_word_i if urun_en_i is 1, and all zeros otherwise. Each such slot sets the sticky flag urun_o.
- R7: When mclk_en_i is 1, the divider counts rising edges of mclk_i instead of system clocks, so a bit-clock period lasts 2×(div_i+1) mclk_i periods.
- R8: edge_sel_i = 0 selects driving on the falling bit-clock edge and sampling on the rising edge; edge_sel_i = 1 swaps the two edges. In master mode, the bit clock rests at the level edge_sel_i while the port is disabled.
- R9: The transmit FIFO holds 4 words. tx_full_o is high when it holds 4. A write to a full FIFO is dropped and sets the sticky flag tx_ovf_o.
- R10: The receive FIFO holds 4 words, with the oldest word shown on rx_data_o. A word received while the FIFO is full is dropped and sets the sticky flag rx_ovf_o.
- R11: Each bit of flag_clr_i set for one cycle clears one sticky flag: bit 0 clears tx_ovf_o, bit 1 clears rx_ovf_o and bit 2 clears urun_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable; low stops framing |
| master_i | input | 1 | 1 = clock master, 0 = clock slave |
| edge_sel_i | input | 1 | Bit-clock edge selection for driving and sampling |
| mclk_en_i | input | 1 | 1 = divide mclk_i, 0 = divide clk_i |
| mclk_i | input | 1 | Dedicated master clock input |
| div_i | input | 8 | Divider value N |
| rx_dis_i | input | 1 | Blocks received words from entering the FIFO |
| urun_en_i | input | 1 | Enables the filler word on transmit underrun |
| urun_word_i | input | 16 | Filler word |
| tx_wr_i | input | 1 | Transmit FIFO write strobe |
| tx_data_i | input | 16 | Transmit FIFO write data |
| tx_full_o | output | 1 | Transmit FIFO full |
| rx_rd_i | input | 1 | Receive FIFO pop strobe |
| rx_data_o | output | 16 | Oldest received word |
| rx_empty_o | output | 1 | Receive FIFO empty |
| flag_clr_i | input | 3 | Write-one-to-clear for the sticky flags |
| tx_ovf_o | output | 1 | Sticky transmit overflow |
| rx_ovf_o | output | 1 | Sticky receive overflow |
| urun_o | output | 1 | Sticky transmit underrun |
| bclk_i | input | 1 | External bit clock (slave) |
| lrclk_i | input | 1 | External frame clock (slave) |
| sdi_i | input | 1 | Serial data in |
| bclk_o | output | 1 | Generated bit clock (master) |
| lrclk_o | output | 1 | Generated frame clock (master) |
| sdo_o | output | 1 | Serial data out |

## Verification
The assertions take some things about the inputs for granted:
- master_i does not change while en_i is high.
- In slave mode, the external bit clock changes slowly enough that each level is seen for several system clocks.
- The frame clock moves only on the drive edge.
- In loopback in master mode with the system clock selected, div_i is at least 3. This lets serial data out cross the two-flop input synchronizer before the next sampling edge.

The stimulus keeps to these limits:
- Mode and divider are changed only while the port is disabled.
- Random dividers are drawn from 3 to 6.
- The bench's own slave-side clock is driven with eight system clocks per half period, and the frame clock is changed only together with the drive edge.

// File: rtl/aud_port_pkg.sv
package aud_port_pkg;
  typedef struct packed {
    logic drive;
    logic samp;
  } edge_t;

  localparam int unsigned FLG_TXOVF = 0;
  localparam int unsigned FLG_RXOVF = 1;
  localparam int unsigned FLG_URUN  = 2;
  localparam int unsigned FLG_N     = 3;
endpackage

// File: rtl/aud_fifo.sv
module aud_fifo #(
  parameter int unsigned W = 16,
  parameter int unsigned D = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned AW = (D > 1) ? $clog2(D) : 1;
  localparam int unsigned CW = $clog2(D + 1);

  logic [W-1:0]  mem_q [D];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          wr_ok, rd_ok;

  assign full_o  = (cnt_q == CW'(D));
  assign empty_o = (cnt_q == '0);
  assign wr_ok   = wr_i & ~full_o;
  assign rd_ok   = rd_i & ~empty_o;
  assign rdata_o = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= (wp_q == AW'(D-1)) ? '0 : wp_q + 1'b1;
      if (rd_ok) rp_q <= (rp_q == AW'(D-1)) ? '0 : rp_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wp_q] <= wdata_i;
  end

  // R9
  fifo_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_i && !rd_i) |=> (full_o && $stable(wp_q)));
endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
  import aud_port_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_i,
  input  logic             run_i,
  input  logic             edge_sel_i,
  input  logic             mclk_en_i,
  input  logic             mclk_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             bclk_i,
  input  logic             lrclk_i,
  input  logic             sdi_i,
  output edge_t            stb_o,
  output logic             lr_fall_o,
  output logic             sdi_s_o,
  output logic             bclk_o
);
  logic [2:0]       mclk_s, bclk_s, lr_s;
  logic [1:0]       sdi_s;
  logic [DIV_W-1:0] cnt_q;
  logic             ph_q;
  logic             tick, gen_on, wrap, b_rise, b_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mclk_s <= '0;
      bclk_s <= '0;
      lr_s   <= '0;
      sdi_s  <= '0;
    end else begin
      mclk_s <= {mclk_s[1:0], mclk_i};
      bclk_s <= {bclk_s[1:0], bclk_i};
      lr_s   <= {lr_s[1:0], lrclk_i};
      sdi_s  <= {sdi_s[0], sdi_i};
    end
  end

  // divider source select
  assign tick   = mclk_en_i ? (mclk_s[1] & ~mclk_s[2]) : 1'b1;
  assign gen_on = master_i & run_i;
  assign wrap   = gen_on & tick & (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (!gen_on) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (tick) begin
      if (cnt_q == div_i) begin
        cnt_q <= '0;
        ph_q  <= ~ph_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign b_rise = bclk_s[1] & ~bclk_s[2];
  assign b_fall = ~bclk_s[1] & bclk_s[2];

  always_comb begin
    if (master_i) begin
      stb_o.samp  = wrap & ~ph_q;
      stb_o.drive = wrap & ph_q;
    end else begin
      stb_o.samp  = edge_sel_i ? b_fall : b_rise;
      stb_o.drive = edge_sel_i ? b_rise : b_fall;
    end
  end

  assign lr_fall_o = ~master_i & ~lr_s[1] & lr_s[2];
  assign sdi_s_o   = sdi_s[1];
  // phase 0->1 is always the sampling edge
  assign bclk_o    = master_i & (ph_q ^ edge_sel_i);

  // R1
  bclk_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && gen_on && $past(gen_on) &&
     $stable(edge_sel_i) && (bclk_o != $past(bclk_o))) |-> $past(wrap));
endmodule

// File: rtl/aud_engine.sv
module aud_engine
  import aud_port_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         master_i,
  input  edge_t        stb_i,
  input  logic         lr_fall_i,
  input  logic         sdi_i,
  input  logic         rx_dis_i,
  input  logic         urun_en_i,
  input  logic [W-1:0] urun_word_i,
  input  logic         tx_empty_i,
  input  logic [W-1:0] tx_data_i,
  output logic         tx_pop_o,
  output logic         rx_push_o,
  output logic [W-1:0] rx_word_o,
  output logic         urun_evt_o,
  output logic         run_o,
  output logic         slot_o,
  output logic         sdo_o
);
  localparam int unsigned BW = $clog2(W);
  localparam logic [BW-1:0] LAST = BW'(W-1);

  logic          run_q, slot_q;
  logic [BW-1:0] bit_q, rcnt_q;
  logic [W-1:0]  tx_sr, rx_sr, next_word;
  logic          start, load;

  assign start     = en_i & ~run_q & (master_i | lr_fall_i);
  assign load      = start | (run_q & stb_i.drive & (bit_q == LAST));
  assign tx_pop_o  = load & ~tx_empty_i;
  assign urun_evt_o = load & tx_empty_i;
  assign next_word = ~tx_empty_i ? tx_data_i : (urun_en_i ? urun_word_i : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      slot_q <= 1'b0;
      bit_q  <= '0;
      rcnt_q <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
    end else if (!en_i) begin
      run_q  <= 1'b0;
      slot_q <= 1'b0;
      bit_q  <= '0;
      rcnt_q <= '0;
      tx_sr  <= '0;
    end else if (start) begin
      run_q  <= 1'b1;
      slot_q <= 1'b0;
      bit_q  <= '0;
      rcnt_q <= '0;
      tx_sr  <= next_word;
    end else if (run_q) begin
      if (stb_i.drive) begin
        if (bit_q == LAST) begin
          tx_sr  <= next_word;
          bit_q  <= '0;
          slot_q <= ~slot_q;
        end else begin
          tx_sr <= {tx_sr[W-2:0], 1'b0};
          bit_q <= bit_q + 1'b1;
        end
      end
      if (stb_i.samp) begin
        rx_sr  <= {rx_sr[W-2:0], sdi_i};
        rcnt_q <= rcnt_q + 1'b1;
      end
    end
  end

  assign rx_push_o = run_q & stb_i.samp & (rcnt_q == LAST) & ~rx_dis_i;
  assign rx_word_o = {rx_sr[W-2:0], sdi_i};
  assign sdo_o     = run_q & tx_sr[W-1];
  assign run_o     = run_q;
  assign slot_o    = slot_q;

  // R4
  slave_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && !$past(run_q) && run_q) |-> $past(lr_fall_i));

  // R3
  slot_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && (slot_q != $past(slot_q))) |-> (bit_q == '0));
endmodule

// File: rtl/aud_port.sv
module aud_port
  import aud_port_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned FIFO_D = 4,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              master_i,
  input  logic              edge_sel_i,
  input  logic              mclk_en_i,
  input  logic              mclk_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              rx_dis_i,
  input  logic              urun_en_i,
  input  logic [WORD_W-1:0] urun_word_i,
  input  logic              tx_wr_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic              tx_full_o,
  input  logic              rx_rd_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_empty_o,
  input  logic [FLG_N-1:0]  flag_clr_i,
  output logic              tx_ovf_o,
  output logic              rx_ovf_o,
  output logic              urun_o,
  input  logic              bclk_i,
  input  logic              lrclk_i,
  input  logic              sdi_i,
  output logic              bclk_o,
  output logic              lrclk_o,
  output logic              sdo_o
);
  edge_t             stb;
  logic              lr_fall, sdi_s, run, slot;
  logic              tx_pop, tx_empty, rx_push, rx_full, urun_evt;
  logic [WORD_W-1:0] tx_head, rx_word;
  logic [FLG_N-1:0]  flg_q, flg_set;

  aud_fifo #(.W(WORD_W), .D(FIFO_D)) u_txf (
    .clk_i, .rst_ni,
    .wr_i(tx_wr_i), .wdata_i(tx_data_i),
    .rd_i(tx_pop), .rdata_o(tx_head),
    .full_o(tx_full_o), .empty_o(tx_empty)
  );

  aud_fifo #(.W(WORD_W), .D(FIFO_D)) u_rxf (
    .clk_i, .rst_ni,
    .wr_i(rx_push), .wdata_i(rx_word),
    .rd_i(rx_rd_i), .rdata_o(rx_data_o),
    .full_o(rx_full), .empty_o(rx_empty_o)
  );

  aud_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk_i, .rst_ni, .master_i, .run_i(run), .edge_sel_i,
    .mclk_en_i, .mclk_i, .div_i, .bclk_i, .lrclk_i, .sdi_i,
    .stb_o(stb), .lr_fall_o(lr_fall), .sdi_s_o(sdi_s), .bclk_o
  );

  aud_engine #(.W(WORD_W)) u_eng (
    .clk_i, .rst_ni, .en_i, .master_i,
    .stb_i(stb), .lr_fall_i(lr_fall), .sdi_i(sdi_s), .rx_dis_i,
    .urun_en_i, .urun_word_i,
    .tx_empty_i(tx_empty), .tx_data_i(tx_head),
    .tx_pop_o(tx_pop), .rx_push_o(rx_push), .rx_word_o(rx_word),
    .urun_evt_o(urun_evt), .run_o(run), .slot_o(slot), .sdo_o
  );

  assign lrclk_o = master_i & run & slot;

  always_comb begin
    flg_set            = '0;
    flg_set[FLG_TXOVF] = tx_wr_i & tx_full_o;
    flg_set[FLG_RXOVF] = rx_push & rx_full;
    flg_set[FLG_URUN]  = urun_evt;
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= (flg_q & ~flag_clr_i) | flg_set;
  end

  assign tx_ovf_o = flg_q[FLG_TXOVF];
  assign rx_ovf_o = flg_q[FLG_RXOVF];
  assign urun_o   = flg_q[FLG_URUN];

  // R6
  urun_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urun_evt |=> urun_o);

  // R5
  rx_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_dis_i && !rx_rd_i && rx_empty_o) |=> rx_empty_o);

  // R10
  rx_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push && rx_full && !rx_rd_i) |=> (rx_ovf_o && !rx_empty_o));
endmodule

// File: tb/aud_port_bench.sv
`timescale 1ns/1ps
module aud_port_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en = 0, master = 0, edge_sel = 0, mclk_en = 0, mclk = 0;
  logic [7:0]  div = 8'd3;
  logic        rx_dis = 0, urun_en = 0, tx_wr = 0, rx_rd = 0;
  logic [15:0] urun_word = '0, tx_data = '0;
  logic [2:0]  flag_clr = '0;
  logic        bclk_drv = 0, lr_drv = 0, sdi_drv = 0, lb = 0;
  logic        tx_full, rx_empty, tx_ovf, rx_ovf, urun, bclk, lrclk, sdo, sdi_w;
  logic [15:0] rx_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;
  always begin
    repeat (2) @(negedge clk);
    mclk = ~mclk;
  end

  assign sdi_w = lb ? sdo : sdi_drv;

  aud_port u_aud_port (
    .clk_i(clk), .rst_ni, .en_i(en), .master_i(master), .edge_sel_i(edge_sel),
    .mclk_en_i(mclk_en), .mclk_i(mclk), .div_i(div), .rx_dis_i(rx_dis),
    .urun_en_i(urun_en), .urun_word_i(urun_word), .tx_wr_i(tx_wr),
    .tx_data_i(tx_data), .tx_full_o(tx_full), .rx_rd_i(rx_rd),
    .rx_data_o(rx_data), .rx_empty_o(rx_empty), .flag_clr_i(flag_clr),
    .tx_ovf_o(tx_ovf), .rx_ovf_o(rx_ovf), .urun_o(urun),
    .bclk_i(bclk_drv), .lrclk_i(lr_drv), .sdi_i(sdi_w),
    .bclk_o(bclk), .lrclk_o(lrclk), .sdo_o(sdo)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_tx(input logic [15:0] w);
    @(negedge clk);
    tx_wr = 1; tx_data = w;
    @(negedge clk);
    tx_wr = 0;
  endtask

  task automatic read_rx(output logic [15:0] w);
    @(negedge clk);
    w = rx_data; rx_rd = 1;
    @(negedge clk);
    rx_rd = 0;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    flag_clr = 3'b111;
    @(negedge clk);
    flag_clr = 3'b000;
  endtask

  task automatic drain();
    logic [15:0] w;
    @(negedge clk);
    while (!rx_empty) read_rx(w);
  endtask

  function automatic int slot_cycles(input logic [7:0] n);
    return 16 * 2 * (int'(n) + 1);
  endfunction

  // one slave bit: drive edge (fall), hold, sampling edge (rise)
  task automatic sbit(input logic lr, input logic d, output logic s);
    @(negedge clk);
    bclk_drv = 0; lr_drv = lr; sdi_drv = d;
    wait_n(8);
    s = sdo;
    bclk_drv = 1;
    wait_n(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w [5];
    logic [15:0] got, exp_w, a, b, c, d, s_got0, s_got1;
    logic        s;
    int          n, cnt;
    void'($urandom(32'h5eed_a0d1));

    wait_n(3);
    rst_ni = 1;
    wait_n(2);
    // reset state
    chk(sdo == 0 && bclk == 0 && lrclk == 0, "R4 reset outputs", {bclk, lrclk, sdo}, 0);
    chk(rx_empty == 1 && tx_full == 0, "R10 reset fifo", {rx_empty, tx_full}, 2);
    chk({tx_ovf, rx_ovf, urun} == 0, "R11 reset flags", {tx_ovf, rx_ovf, urun}, 0);

    // R9: overfill tx while disabled
    for (int i = 0; i < 5; i++) begin
      w[i] = 16'($urandom);
      write_tx(w[i]);
    end
    wait_n(1);
    chk(tx_full == 1, "R9 tx full", tx_full, 1);
    chk(tx_ovf == 1, "R9 tx overflow flag", tx_ovf, 1);
    @(negedge clk); flag_clr = 3'b001; @(negedge clk); flag_clr = 0;
    chk(tx_ovf == 0, "R11 clear tx_ovf", tx_ovf, 0);

    // R8: master, edge_sel=1, loopback drains the four words
    master = 1; edge_sel = 1; div = 3; urun_en = 1; urun_word = 16'hA5C3; lb = 1;
    wait_n(2);
    chk(bclk == 1, "R8 idle level edge_sel=1", bclk, 1);
    @(negedge clk); en = 1;
    wait_n(4 * slot_cycles(div) + 64);
    for (int i = 0; i < 4; i++) begin
      read_rx(got);
      chk(got == w[i], "R8 R3 loopback word", got, w[i]);
    end
    wait_n(slot_cycles(div));
    read_rx(got);
    chk(got == 16'hA5C3, "R9 dropped word absent, R6 filler", got, 16'hA5C3);
    @(negedge clk); en = 0;
    drain(); clear_flags();

    // R1 R2: edge_sel=0, system clock
    edge_sel = 0; div = 3; wait_n(2);
    @(negedge clk); en = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (!bclk && n < 100);
    chk(n <= 8, "R2 first edge delay", n, 8);
    chk(lrclk == 0, "R2 frame clock left", lrclk, 0);
    n = 0;
    while (bclk)  begin @(negedge clk); n++; end
    while (!bclk) begin @(negedge clk); n++; end
    chk(n == 8, "R1 bit period", n, 8);
    wait_n(3 * slot_cycles(div));
    n = 0;
    while (bclk)  begin @(negedge clk); n++; end
    while (!bclk) begin @(negedge clk); n++; end
    chk(n == 8, "R1 period with empty tx", n, 8);
    @(negedge clk); en = 0;
    drain(); clear_flags();

    // R7: master clock source
    mclk_en = 1; div = 1; wait_n(2);
    @(negedge clk); en = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (!bclk && n < 200);
    n = 0;
    while (bclk)  begin @(negedge clk); n++; end
    while (!bclk) begin @(negedge clk); n++; end
    chk(n == 16, "R7 mclk-divided period", n, 16);
    @(negedge clk); en = 0; mclk_en = 0;
    drain(); clear_flags();

    // R3 R10 R6: random loopback trials
    for (int t = 0; t < 3; t++) begin
      div = 8'(3 + ($urandom % 4));
      urun_word = 16'($urandom);
      urun_en = 1;
      for (int i = 0; i < 4; i++) begin
        w[i] = 16'($urandom);
        write_tx(w[i]);
      end
      @(negedge clk); en = 1;
      wait_n(6 * slot_cycles(div) + 40);
      @(negedge clk); en = 0;
      for (int i = 0; i < 4; i++) begin
        read_rx(got);
        chk(got == w[i], "R3 random loopback", got, w[i]);
      end
      wait_n(1);
      chk(rx_empty == 1, "R10 depth four", rx_empty, 1);
      chk(rx_ovf == 1, "R10 rx overflow flag", rx_ovf, 1);
      chk(urun == 1, "R6 underrun flag", urun, 1);
      clear_flags();
      chk({tx_ovf, rx_ovf, urun} == 0, "R11 clear all", {tx_ovf, rx_ovf, urun}, 0);
    end

    // R6: zeros when filler disabled
    urun_en = 0; urun_word = 16'hFFFF; div = 3;
    @(negedge clk); en = 1;
    wait_n(3 * slot_cycles(div) + 40);
    @(negedge clk); en = 0;
    cnt = 0;
    @(negedge clk);
    while (!rx_empty) begin
      read_rx(got);
      cnt++;
      chk(got == 0, "R6 zero fill", got, 0);
    end
    chk(cnt >= 2, "R6 words received", cnt, 2);
    chk(urun == 1, "R6 flag on zero fill", urun, 1);
    clear_flags();

    // R4 R3: slave mode
    master = 0; lb = 0; edge_sel = 0; urun_en = 0;
    lr_drv = 1; bclk_drv = 0;
    wait_n(10);
    c = 16'($urandom); d = 16'($urandom);
    a = 16'($urandom); b = 16'($urandom);
    write_tx(c); write_tx(d);
    @(negedge clk); en = 1;
    cnt = 0;
    for (int i = 0; i < 4; i++) begin
      sbit(1'b1, 1'($urandom), s);
      if (s) cnt++;
    end
    chk(cnt == 0, "R4 silent before frame", cnt, 0);
    chk(rx_empty == 1, "R4 no capture before frame", rx_empty, 1);
    for (int i = 15; i >= 0; i--) begin
      sbit(1'b0, a[i], s);
      s_got0[i] = s;
    end
    for (int i = 15; i >= 0; i--) begin
      sbit(1'b1, b[i], s);
      s_got1[i] = s;
    end
    sbit(1'b0, 1'b0, s);
    chk(s_got0 == c, "R3 slave left tx", s_got0, c);
    chk(s_got1 == d, "R3 slave right tx", s_got1, d);
    read_rx(got);
    chk(got == a, "R4 slave left rx", got, a);
    read_rx(got);
    chk(got == b, "R4 slave right rx", got, b);
    @(negedge clk); en = 0;
    drain(); clear_flags();

    // R5: receive disabled, transmit continues
    lr_drv = 1; bclk_drv = 0; rx_dis = 1;
    wait_n(10);
    exp_w = 16'($urandom);
    write_tx(exp_w);
    @(negedge clk); en = 1;
    for (int i = 0; i < 2; i++) sbit(1'b1, 1'($urandom), s);
    for (int i = 15; i >= 0; i--) begin
      sbit(1'b0, 1'($urandom), s);
      s_got0[i] = s;
    end
    for (int i = 0; i < 16; i++) sbit(1'b1, 1'($urandom), s);
    sbit(1'b0, 1'b0, s);
    chk(s_got0 == exp_w, "R5 tx while rx disabled", s_got0, exp_w);
    chk(rx_empty == 1, "R5 rx stays empty", rx_empty, 1);
    @(negedge clk); en = 0; rx_dis = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule